// File: doc/BRIEF.md
# Message Segmenter with Per-Segment Retry

This block is the sending side of a message transport. A descriptor names either a data message (a byte length plus a segment size) or a doorbell (a 16-bit event code). For a message the block cuts the payload into numbered segment requests and hands them out one at a time on a valid/ready stream. Each emitted segment then waits for its own response. A response can report done, error or retry, and a retry re-issues only the segment it names. When nothing is left in flight, one status pulse reports whether the whole message succeeded.

A doorbell goes through the same machinery as a one-segment request with no payload. The block keeps only the descriptor; payload bytes are fetched downstream by offset and byte count. A response belongs to a request only when its device IDs are the request's IDs swapped. A retry budget and a response timeout, both given per descriptor, bound how long a message can stay open.

Top module: `msg_segmenter`

## Requirements
- R1: Segment size is 8 << desc_shift bytes (desc_shift 0..5, so 8 to 256 bytes). A message of L bytes is split into ceil(L / size) segments. Segment k starts at byte offset k*size and carries size bytes, except the last, which carries the remainder. Every segment reports the total count on seg_total.
- R2: A message descriptor with length 0, length above 4096, desc_shift above 5 or more than 16 segments is accepted and emits no segment. done_valid=1 with done_ok=0 appears on the clock edge that accepts it.
- R3: Outstanding sends go out one per seg_valid/seg_ready handshake, and the lowest-numbered segment that still needs sending goes first.
- R4: A response is used only when rsp_src equals the descriptor's destination ID, rsp_dst equals its source ID, and the indexed segment is awaiting a response. Any other response has no effect.
- R5: Response status codes are 0 done, 2 retry, and 1 or 3 error. A retry response re-emits only that segment, with the same index, offset and byte count.
- R6: Each message tolerates at most desc_max_retry retry responses. The next retry response fails the message.
- R7: After an error response, no further segment is emitted. Failure is reported once every other emitted segment has received its response or timed out.
- R8: A segment that gets no usable response within desc_timeout cycles of its handshake fails the message. With no other traffic, done_valid rises desc_timeout+2 edges after the handshake edge.
- R9: When every segment has a done response, done_valid=1 with done_ok=1. desc_ready is 0 from acceptance until that report.
- R10: A doorbell descriptor (desc_bell=1) emits one request: seg_bell=1, index 0, total 1, byte count 0, and the event code on seg_event. It completes like a one-segment message.
- R11: done_valid is high for exactly one cycle per descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_bell | input | 1 | 1 = doorbell, 0 = data message |
| desc_len | input | 13 | Message length in bytes |
| desc_shift | input | 3 | Segment size selector, size = 8 << desc_shift |
| desc_src | input | 8 | Source device ID of the requests |
| desc_dst | input | 8 | Destination device ID of the requests |
| desc_event | input | 16 | Doorbell event code |
| desc_max_retry | input | 4 | Retry responses allowed per message |
| desc_timeout | input | 16 | Response timeout in cycles |
| seg_valid | output | 1 | Segment request offered |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_bell | output | 1 | Request is a doorbell |
| seg_index | output | 4 | Segment number |
| seg_total | output | 5 | Segments in the message |
| seg_offset | output | 12 | Byte offset of the segment |
| seg_bytes | output | 9 | Payload bytes in the segment |
| seg_src | output | 8 | Source device ID |
| seg_dst | output | 8 | Destination device ID |
| seg_event | output | 16 | Doorbell event code |
| rsp_valid | input | 1 | Response present |
| rsp_index | input | 4 | Segment the response answers |
| rsp_status | input | 2 | 0 done, 1 error, 2 retry, 3 error |
| rsp_src | input | 8 | Response source device ID |
| rsp_dst | input | 8 | Response destination device ID |
| done_valid | output | 1 | Completion pulse |
| done_ok | output | 1 | 1 = message succeeded |

## Verification
The embedded assertions check, on every cycle, that an emitted segment has an index below its total, a non-zero byte count of at most 256, and a range that fits in the message. They also check that nothing is emitted on the cycle after an error response is accepted, and that the completion flag never lasts two cycles. Properties that depend on history are shown only by the directed scenarios. These include the resend carrying the same offset after a retry, the retry budget running out, the exact cycle a timeout is reported, responses with unswapped IDs being ignored, and the 16-segment boundary with a short last segment.

// File: rtl/msg_segmenter.sv
module msg_segmenter #(
  parameter int NSEG   = 16,
  parameter int MAXSEG = 256,
  parameter int LW     = 13,
  parameter int TW     = 16,
  parameter int RW     = 4,
  parameter int IDW    = 8,
  parameter int EVW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic             desc_bell,
  input  logic [LW-1:0]    desc_len,
  input  logic [2:0]       desc_shift,
  input  logic [IDW-1:0]   desc_src,
  input  logic [IDW-1:0]   desc_dst,
  input  logic [EVW-1:0]   desc_event,
  input  logic [RW-1:0]    desc_max_retry,
  input  logic [TW-1:0]    desc_timeout,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic             seg_bell,
  output logic [$clog2(NSEG)-1:0] seg_index,
  output logic [$clog2(NSEG):0]   seg_total,
  output logic [LW-2:0]    seg_offset,
  output logic [$clog2(MAXSEG):0] seg_bytes,
  output logic [IDW-1:0]   seg_src,
  output logic [IDW-1:0]   seg_dst,
  output logic [EVW-1:0]   seg_event,
  input  logic             rsp_valid,
  input  logic [$clog2(NSEG)-1:0] rsp_index,
  input  logic [1:0]       rsp_status,
  input  logic [IDW-1:0]   rsp_src,
  input  logic [IDW-1:0]   rsp_dst,
  output logic             done_valid,
  output logic             done_ok
);
  localparam int IW     = $clog2(NSEG);
  localparam int CW     = IW + 1;
  localparam int BW     = $clog2(MAXSEG) + 1;
  localparam int MAXSH  = $clog2(MAXSEG) - 3;
  localparam int MAXLEN = NSEG * MAXSEG;

  typedef enum logic [1:0] {S_NONE, S_SEND, S_WAIT, S_DONE} seg_st_t;

  seg_st_t         st  [NSEG];
  logic [TW-1:0]   tmr [NSEG];
  logic            run, abort_q, bell_q;
  logic [LW-1:0]   len_q;
  logic [2:0]      sh_q;
  logic [CW-1:0]   tot_q;
  logic [IDW-1:0]  src_q, dst_q;
  logic [EVW-1:0]  ev_q;
  logic [RW-1:0]   lim_q, rcnt_q;
  logic [TW-1:0]   to_q;

  // descriptor decode
  logic [3:0]  sh4_in;
  logic [LW-1:0] sz_in;
  logic [LW:0] sum_in, tot_w;
  logic        bad, accept, start;
  logic [CW-1:0] tot_in;

  assign sh4_in = {1'b0, desc_shift} + 4'd3;
  assign sz_in  = LW'(1) << sh4_in;
  assign sum_in = {1'b0, desc_len} + {1'b0, sz_in} - 1'b1;
  assign tot_w  = sum_in >> sh4_in;
  assign bad    = !desc_bell && (desc_len == '0 || 32'(desc_len) > MAXLEN ||
                                 32'(desc_shift) > MAXSH || 32'(tot_w) > NSEG);
  assign tot_in = desc_bell ? CW'(1) : tot_w[CW-1:0];
  assign desc_ready = !run;
  assign accept = desc_valid && !run;
  assign start  = accept && !bad;

  // send selection and occupancy
  logic [IW-1:0] pick;
  logic          any_send, any_wait;
  always_comb begin
    pick = '0;
    any_send = 1'b0;
    any_wait = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (!any_send && st[i] == S_SEND) begin
        pick = IW'(i);
        any_send = 1'b1;
      end
      if (st[i] == S_WAIT) any_wait = 1'b1;
    end
  end

  logic          fire;
  logic [3:0]    sh4_q;
  logic [LW-1:0] off_w, bytes_w;
  assign seg_valid = run && !abort_q && any_send;
  assign fire      = seg_valid && seg_ready;
  assign sh4_q     = {1'b0, sh_q} + 4'd3;
  assign off_w     = LW'(pick) << sh4_q;
  assign bytes_w   = (CW'(pick) == tot_q - 1'b1) ? len_q - off_w : LW'(1) << sh4_q;
  assign seg_bell   = bell_q;
  assign seg_index  = pick;
  assign seg_total  = tot_q;
  assign seg_offset = bell_q ? '0 : off_w[LW-2:0];
  assign seg_bytes  = bell_q ? '0 : bytes_w[BW-1:0];
  assign seg_src    = src_q;
  assign seg_dst    = dst_q;
  assign seg_event  = ev_q;

  // response matching
  logic rsp_hit, rsp_err, rsp_retry, retry_over, finish;
  logic [NSEG-1:0] to_vec;
  assign rsp_hit    = run && rsp_valid && rsp_src == dst_q && rsp_dst == src_q &&
                      32'(rsp_index) < NSEG && st[rsp_index] == S_WAIT;
  assign rsp_retry  = rsp_hit && rsp_status == 2'd2;
  assign rsp_err    = rsp_hit && (rsp_status == 2'd1 || rsp_status == 2'd3);
  assign retry_over = rsp_retry && rcnt_q == lim_q;
  assign finish     = run && !any_wait && (abort_q || !any_send);

  always_comb
    for (int i = 0; i < NSEG; i++)
      to_vec[i] = run && st[i] == S_WAIT && tmr[i] == to_q &&
                  !(rsp_hit && 32'(rsp_index) == i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; abort_q <= 1'b0; bell_q <= 1'b0;
      len_q <= '0; sh_q <= '0; tot_q <= '0; src_q <= '0; dst_q <= '0;
      ev_q <= '0; lim_q <= '0; rcnt_q <= '0; to_q <= '0;
      done_valid <= 1'b0; done_ok <= 1'b0;
    end else begin
      done_valid <= (accept && bad) || finish;
      done_ok    <= finish && !abort_q;
      if (start) begin
        run <= 1'b1; abort_q <= 1'b0; bell_q <= desc_bell;
        len_q <= desc_len; sh_q <= desc_shift; tot_q <= tot_in;
        src_q <= desc_src; dst_q <= desc_dst; ev_q <= desc_event;
        lim_q <= desc_max_retry; rcnt_q <= '0; to_q <= desc_timeout;
      end else begin
        if (finish) run <= 1'b0;
        if (rsp_err || retry_over || |to_vec) abort_q <= 1'b1;
        if (rsp_retry && !retry_over) rcnt_q <= rcnt_q + 1'b1;
      end
    end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st[g]  <= S_NONE;
        tmr[g] <= '0;
      end else if (start) begin
        st[g]  <= (g < 32'(tot_in)) ? S_SEND : S_NONE;
        tmr[g] <= '0;
      end else if (fire && 32'(pick) == g) begin
        st[g]  <= S_WAIT;
        tmr[g] <= '0;
      end else if (rsp_hit && 32'(rsp_index) == g) begin
        if (rsp_retry && !retry_over && !abort_q) st[g] <= S_SEND;
        else                                      st[g] <= S_DONE;
      end else if (to_vec[g]) begin
        st[g] <= S_DONE;
      end else if (st[g] == S_WAIT) begin
        tmr[g] <= tmr[g] + 1'b1;
      end else if (abort_q && st[g] == S_SEND) begin
        st[g] <= S_NONE;
      end
  end

  assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> CW'(seg_index) < seg_total);
  assert_seg_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_bell |-> seg_bytes != '0 && 32'(seg_bytes) <= MAXSEG);
  assert_seg_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_bell |-> LW'(seg_offset) + LW'(seg_bytes) <= len_q);
  assert_halt_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> !seg_valid);
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

// File: tb/tb_msg_segmenter.sv
module tb_msg_segmenter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 0, desc_ready, desc_bell = 0;
  logic [12:0] desc_len = 0;
  logic [2:0]  desc_shift = 0;
  logic [7:0]  desc_src = 8'h11, desc_dst = 8'h22;
  logic [15:0] desc_event = 0;
  logic [3:0]  desc_max_retry = 0;
  logic [15:0] desc_timeout = 16'd1000;
  logic seg_valid, seg_ready = 0, seg_bell;
  logic [3:0] seg_index;
  logic [4:0] seg_total;
  logic [11:0] seg_offset;
  logic [8:0] seg_bytes;
  logic [7:0] seg_src, seg_dst;
  logic [15:0] seg_event;
  logic rsp_valid = 0;
  logic [3:0] rsp_index = 0;
  logic [1:0] rsp_status = 0;
  logic [7:0] rsp_src = 0, rsp_dst = 0;
  logic done_valid, done_ok;

  int checks = 0, errors = 0;
  int c_idx, c_tot, c_off, c_bytes, c_bell, c_ev;

  always #4 clk = ~clk;

  msg_segmenter dut (.*);

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_desc(input bit bell, input int len, input int sh, input int mr, input int to, input int ev);
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    desc_bell = bell; desc_len = 13'(len); desc_shift = 3'(sh);
    desc_max_retry = 4'(mr); desc_timeout = 16'(to); desc_event = 16'(ev);
    desc_valid = 1;
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic take_seg(output bit got);
    got = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (seg_valid) begin
        c_idx = seg_index; c_tot = seg_total; c_off = seg_offset;
        c_bytes = seg_bytes; c_bell = seg_bell; c_ev = seg_event;
        got = 1; seg_ready = 1;
        @(negedge clk);
        seg_ready = 0;
        break;
      end
    end
  endtask

  task automatic respond(input int idx, input int status, input logic [7:0] s, input logic [7:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_index = 4'(idx); rsp_status = 2'(status); rsp_src = s; rsp_dst = d;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic wait_done(output bit ok, output int cyc);
    cyc = 0; ok = 0;
    while (!done_valid && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done_valid) begin cyc = -1; return; end
    ok = done_ok;
    @(negedge clk);
    chk(!done_valid, "R11", "done pulse width", done_valid, 0);
  endtask

  task automatic expect_seg(input string req, input int idx, input int off, input int bytes, input int tot);
    bit got;
    take_seg(got);
    chk(got, req, "segment emitted", got, 1);
    chk(c_idx == idx && c_off == off && c_bytes == bytes && c_tot == tot, req,
        $sformatf("seg idx/off/bytes/total %0d/%0d/%0d/%0d", c_idx, c_off, c_bytes, c_tot),
        c_off, off);
  endtask

  task automatic t_reset;
    chk(desc_ready == 1, "R9", "desc_ready after reset", desc_ready, 1);
    chk(seg_valid == 0, "R3", "seg_valid after reset", seg_valid, 0);
    chk(done_valid == 0, "R11", "done_valid after reset", done_valid, 0);
  endtask

  task automatic t_basic;
    bit ok; int cyc;
    send_desc(0, 100, 2, 0, 1000, 0);
    chk(desc_ready == 0, "R9", "desc_ready while busy", desc_ready, 0);
    expect_seg("R1", 0, 0, 32, 4);
    expect_seg("R3", 1, 32, 32, 4);
    expect_seg("R3", 2, 64, 32, 4);
    expect_seg("R1", 3, 96, 4, 4);
    respond(3, 0, 8'h22, 8'h11);
    respond(1, 0, 8'h22, 8'h11);
    respond(0, 0, 8'h22, 8'h11);
    chk(done_valid == 0, "R9", "no completion with segment pending", done_valid, 0);
    respond(2, 0, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 1 && cyc >= 0, "R9", "message success", ok, 1);
  endtask

  task automatic t_bell;
    bit ok, seen; int cyc;
    bit got;
    send_desc(1, 0, 0, 0, 1000, 16'hBEEF);
    take_seg(got);
    chk(got && c_bell == 1 && c_idx == 0 && c_tot == 1 && c_bytes == 0, "R10",
        "doorbell shape", c_bytes, 0);
    chk(c_ev == 16'hBEEF, "R10", "doorbell event", c_ev, 16'hBEEF);
    respond(0, 0, 8'h11, 8'h22);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done_valid) seen = 1;
    end
    chk(!seen && !desc_ready, "R4", "unswapped IDs ignored", seen, 0);
    respond(0, 0, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 1, "R10", "doorbell completes", ok, 1);
  endtask

  task automatic t_retry;
    bit ok; int cyc;
    send_desc(0, 128, 3, 3, 1000, 0);
    expect_seg("R1", 0, 0, 64, 2);
    expect_seg("R1", 1, 64, 64, 2);
    respond(1, 2, 8'h22, 8'h11);
    expect_seg("R5", 1, 64, 64, 2);
    @(negedge clk);
    chk(seg_valid == 0, "R5", "only retried segment resent", seg_valid, 0);
    respond(0, 0, 8'h22, 8'h11);
    respond(1, 0, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 1, "R5", "success after retry", ok, 1);
  endtask

  task automatic t_retry_limit;
    bit ok; int cyc;
    send_desc(0, 8, 0, 1, 1000, 0);
    expect_seg("R6", 0, 0, 8, 1);
    respond(0, 2, 8'h22, 8'h11);
    expect_seg("R6", 0, 0, 8, 1);
    respond(0, 2, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 0 && cyc >= 0, "R6", "retry budget exhausted fails", ok, 0);
  endtask

  task automatic t_error;
    bit ok, bad_seen; int cyc;
    send_desc(0, 96, 2, 0, 1000, 0);
    expect_seg("R7", 0, 0, 32, 3);
    expect_seg("R7", 1, 32, 32, 3);
    respond(0, 1, 8'h22, 8'h11);
    bad_seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (seg_valid || done_valid) bad_seen = 1;
    end
    chk(!bad_seen, "R7", "no send or report while segment outstanding", bad_seen, 0);
    respond(1, 0, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 0 && cyc >= 0, "R7", "error reported after drain", ok, 0);
  endtask

  task automatic t_timeout;
    bit ok; int cyc;
    send_desc(0, 16, 4, 0, 20, 0);
    expect_seg("R8", 0, 0, 16, 1);
    wait_done(ok, cyc);
    chk(ok == 0, "R8", "timeout fails message", ok, 0);
    chk(cyc == 22, "R8", "timeout report cycle", cyc, 22);
  endtask

  task automatic t_reject;
    bit ok, sent; int cyc;
    send_desc(0, 4096, 0, 0, 1000, 0);
    sent = seg_valid;
    wait_done(ok, cyc);
    chk(ok == 0 && cyc == 0 && !sent, "R2", "too many segments rejected", cyc, 0);
    send_desc(0, 64, 6, 0, 1000, 0);
    wait_done(ok, cyc);
    chk(ok == 0 && cyc == 0, "R2", "oversize segment rejected", cyc, 0);
    send_desc(0, 0, 2, 0, 1000, 0);
    wait_done(ok, cyc);
    chk(ok == 0 && cyc == 0, "R2", "zero length rejected", cyc, 0);
  endtask

  task automatic t_full;
    bit ok; int cyc;
    send_desc(0, 4095, 5, 0, 1000, 0);
    for (int k = 0; k < 15; k++) expect_seg("R3", k, k * 256, 256, 16);
    expect_seg("R1", 15, 3840, 255, 16);
    for (int k = 0; k < 16; k++) respond(k, 0, 8'h22, 8'h11);
    wait_done(ok, cyc);
    chk(ok == 1, "R9", "16-segment message success", ok, 1);
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_bell;
    t_retry;
    t_retry_limit;
    t_error;
    t_timeout;
    t_reject;
    t_full;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule